// File: doc/BRIEF.md
# Reloadable Down-Counting Event Timer

This block is a 16-bit countdown timer that measures intervals in units of a prescaled tick. A fixed-rate base strobe (nominally 6.78 MHz, delivered as a one-cycle enable in the system clock domain) feeds a 12-bit divider. A start command copies the reload value into the counter. The counter then drops by one on each prescaled tick. When the count runs out, a sticky interrupt flag is raised.

Depending on the auto-restart input, the timer either halts at zero, which makes it a one-shot or time-out counter, or copies the reload value in again and keeps going, which makes it a periodic timer. A stop command freezes the count. The live count, the running status, the sticky flag and the enable-gated interrupt line are all outputs. The start command is a single-cycle pulse and is never held as state.

Top module: `evt_countdown_timer`

## Requirements
- R1: With prescaler value P, one timer tick occurs on every (2·P+1)-th base strobe counted from the start command. The divider does not advance in cycles where `base_tick_i` is low.
- R2: A `start_i` pulse loads `reload_i` into the counter and sets `running_o` in the next cycle. This holds whether the timer was idle or already running.
- R3: While running, each timer tick on which the count is above 1 lowers `count_o` by exactly one.
- R4: A tick with the count at 1 or 0 is an expiry. Without auto-restart, the count becomes 0 and `running_o` falls. With a reload value of 0, the first tick after start is an expiry.
- R5: An expiry sets `irq_flag_o`. The flag stays set until an `irq_clr_i` pulse. If a set and a clear fall in the same cycle, the set wins.
- R6: `irq_o` is high exactly when `irq_flag_o` and `irq_en_i` are both high.
- R7: With `auto_restart_i` high, an expiry loads `reload_i` again and the timer keeps running. A reload value of R therefore gives one expiry every R ticks.
- R8: A `stop_i` pulse clears `running_o` and leaves `count_o` unchanged, even if a tick falls in the same cycle. While stopped, the count holds.
- R9: Changing `reload_i` while the timer runs does not alter the current count. The new value applies at the next start or auto-restart.
- R10: When `start_i` and `stop_i` arrive in the same cycle, start takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| base_tick_i | input | 1 | One-cycle strobe at the base rate |
| presc_i | input | 12 | Prescaler value P (tick every 2P+1 strobes) |
| reload_i | input | 16 | Value loaded on start or auto-restart |
| auto_restart_i | input | 1 | 1: reload and continue on expiry |
| irq_en_i | input | 1 | Enables the flag onto `irq_o` |
| irq_clr_i | input | 1 | Clears the sticky interrupt flag |
| start_i | input | 1 | Start-now pulse |
| stop_i | input | 1 | Stop pulse |
| count_o | output | 16 | Live counter value |
| running_o | output | 1 | Counter will decrement on next tick |
| irq_flag_o | output | 1 | Sticky expiry flag |
| irq_o | output | 1 | Enabled interrupt request |

## Verification
On every cycle, the assertions check the following:
- the effect of start, which loads the value and sets running;
- the effect of stop, which freezes the count and clears running;
- the single-step decrement on a tick;
- that the count holds while idle;
- that an expiry sets the flag and the flag stays sticky;
- that the divider holds when no strobe arrives.

The rest can only be shown by the bench's directed scenarios:
- the exact tick period for a given prescaler value;
- the expiry cycle for both one-shot and auto-restart operation;
- the zero-reload case;
- that a mid-run change of the reload value is ignored until the next start.

// File: rtl/evt_tmr_pkg.sv
package evt_tmr_pkg;
  // divider terminal value for prescaler p: period is this value + 1
  function automatic logic [31:0] div_span(input logic [31:0] p);
    return p << 1;
  endfunction

  // a tick at or below this count expires the timer
  function automatic logic is_last(input logic [31:0] cnt);
    return cnt <= 32'd1;
  endfunction
endpackage

// File: rtl/evt_tmr_prescale.sv
module evt_tmr_prescale #(
  parameter int PRE_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic             base_i,
  input  logic [PRE_W-1:0] presc_i,
  output logic             tick_o
);
  localparam int DIV_W = PRE_W + 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] span_w;

  assign span_w = DIV_W'(evt_tmr_pkg::div_span(32'(presc_i)));
  assign tick_o = run_i && !restart_i && base_i && (div_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                div_q <= '0;
    else if (restart_i)        div_q <= span_w;
    else if (run_i && base_i) begin
      if (div_q == '0)         div_q <= span_w;
      else                     div_q <= div_q - 1'b1;
    end
  end

  // R1: divider holds when there is no base strobe
  p_div_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!base_i && !restart_i) |=> $stable(div_q));
  // R1: a tick only occurs on a base strobe
  p_tick_on_base_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |-> base_i);
endmodule

// File: rtl/evt_tmr_core.sv
module evt_tmr_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic             auto_restart_i,
  input  logic             irq_clr_i,
  output logic [CNT_W-1:0] count_o,
  output logic             running_o,
  output logic             irq_flag_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic             irq_q;
  logic             expire_w;
  logic             step_w;

  assign expire_w = tick_i && run_q && !stop_i && evt_tmr_pkg::is_last(32'(cnt_q));
  assign step_w   = tick_i && run_q && !stop_i && !evt_tmr_pkg::is_last(32'(cnt_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (start_i) begin
      cnt_q <= reload_i;
      run_q <= 1'b1;
    end else if (stop_i) begin
      run_q <= 1'b0;
    end else if (expire_w) begin
      if (auto_restart_i) cnt_q <= reload_i;
      else begin
        cnt_q <= '0;
        run_q <= 1'b0;
      end
    end else if (step_w) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         irq_q <= 1'b0;
    else if (expire_w)  irq_q <= 1'b1;
    else if (irq_clr_i) irq_q <= 1'b0;
  end

  assign count_o    = cnt_q;
  assign running_o  = run_q;
  assign irq_flag_o = irq_q;

  p_start_loads_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (count_o == $past(reload_i)) && running_o);
  p_dec_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_w && !start_i) |=> count_o == $past(count_o) - 1'b1);
  p_expire_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    expire_w |=> irq_flag_o);
  p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag_o && !irq_clr_i) |=> irq_flag_o);
  p_stop_freezes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !start_i) |=> !running_o && (count_o == $past(count_o)));
  p_idle_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!running_o && !start_i) |=> $stable(count_o));
endmodule

// File: rtl/evt_countdown_timer.sv
module evt_countdown_timer #(
  parameter int CNT_W = 16,
  parameter int PRE_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             base_tick_i,
  input  logic [PRE_W-1:0] presc_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic             auto_restart_i,
  input  logic             irq_en_i,
  input  logic             irq_clr_i,
  input  logic             start_i,
  input  logic             stop_i,
  output logic [CNT_W-1:0] count_o,
  output logic             running_o,
  output logic             irq_flag_o,
  output logic             irq_o
);
  logic tick_w;

  evt_tmr_prescale #(.PRE_W(PRE_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .run_i(running_o), .restart_i(start_i),
    .base_i(base_tick_i), .presc_i(presc_i), .tick_o(tick_w)
  );

  evt_tmr_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_w), .start_i(start_i),
    .stop_i(stop_i), .reload_i(reload_i), .auto_restart_i(auto_restart_i),
    .irq_clr_i(irq_clr_i), .count_o(count_o), .running_o(running_o),
    .irq_flag_o(irq_flag_o)
  );

  assign irq_o = irq_flag_o & irq_en_i;

  p_irq_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> irq_flag_o && irq_en_i);
endmodule

// File: tb/evt_countdown_timer_tb_top.sv
module evt_countdown_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        base_tick_i = 1'b1;
  logic [11:0] presc_i = '0;
  logic [15:0] reload_i = '0;
  logic        auto_restart_i = 1'b0;
  logic        irq_en_i = 1'b0;
  logic        irq_clr_i = 1'b0;
  logic        start_i = 1'b0;
  logic        stop_i = 1'b0;
  logic [15:0] count_o;
  logic        running_o, irq_flag_o, irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  evt_countdown_timer dut_i (
    .clk(clk), .rst_n(rst_n), .base_tick_i(base_tick_i), .presc_i(presc_i),
    .reload_i(reload_i), .auto_restart_i(auto_restart_i), .irq_en_i(irq_en_i),
    .irq_clr_i(irq_clr_i), .start_i(start_i), .stop_i(stop_i),
    .count_o(count_o), .running_o(running_o), .irq_flag_o(irq_flag_o), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clocks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_start(input int rv);
    reload_i = 16'(rv);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic do_clear();
    irq_clr_i = 1'b1;
    @(negedge clk);
    irq_clr_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R2 reset count", int'(count_o), 0);
    chk("R2 reset running", int'(running_o), 0);
    chk("R5 reset flag", int'(irq_flag_o), 0);
  endtask

  task automatic t_load_and_step();
    presc_i = 12'd0; base_tick_i = 1'b1;
    do_start(200);
    chk("R2 load", int'(count_o), 200);
    chk("R2 running", int'(running_o), 1);
    clocks(5);
    chk("R3 step", int'(count_o), 195);
  endtask

  task automatic t_prescale();
    presc_i = 12'd3; // period 7
    do_start(50);
    clocks(6);
    chk("R1 before tick", int'(count_o), 50);
    clocks(1);
    chk("R1 first tick", int'(count_o), 49);
    clocks(7);
    chk("R1 second tick", int'(count_o), 48);
    base_tick_i = 1'b0;
    clocks(20);
    chk("R1 no strobe hold", int'(count_o), 48);
    base_tick_i = 1'b1;
    clocks(7);
    chk("R1 resumes", int'(count_o), 47);
    presc_i = 12'd0;
  endtask

  task automatic t_oneshot();
    auto_restart_i = 1'b0; irq_en_i = 1'b0;
    do_clear();
    do_start(4);
    clocks(3);
    chk("R4 count one", int'(count_o), 1);
    chk("R5 flag not yet", int'(irq_flag_o), 0);
    clocks(1);
    chk("R4 expired count", int'(count_o), 0);
    chk("R4 stopped", int'(running_o), 0);
    chk("R5 flag set", int'(irq_flag_o), 1);
    chk("R6 irq masked", int'(irq_o), 0);
    irq_en_i = 1'b1;
    #1;
    chk("R6 irq enabled", int'(irq_o), 1);
    clocks(3);
    chk("R5 flag sticky", int'(irq_flag_o), 1);
    do_clear();
    chk("R5 flag cleared", int'(irq_flag_o), 0);
    chk("R6 irq low", int'(irq_o), 0);
  endtask

  task automatic t_zero_reload();
    do_start(0);
    chk("R4 zero load running", int'(running_o), 1);
    clocks(1);
    chk("R4 zero expires", int'(irq_flag_o), 1);
    chk("R4 zero stopped", int'(running_o), 0);
    do_clear();
  endtask

  task automatic t_auto();
    auto_restart_i = 1'b1;
    do_start(3);
    clocks(2);
    chk("R7 count one", int'(count_o), 1);
    clocks(1);
    chk("R7 reloaded", int'(count_o), 3);
    chk("R7 still running", int'(running_o), 1);
    chk("R7 flag", int'(irq_flag_o), 1);
    clocks(1);
    chk("R7 continues", int'(count_o), 2);
    auto_restart_i = 1'b0;
    stop_i = 1'b1; @(negedge clk); stop_i = 1'b0;
    do_clear();
  endtask

  task automatic t_stop();
    do_start(100);
    clocks(10);
    stop_i = 1'b1;
    @(negedge clk);
    stop_i = 1'b0;
    chk("R8 frozen", int'(count_o), 90);
    chk("R8 not running", int'(running_o), 0);
    clocks(5);
    chk("R8 holds", int'(count_o), 90);
  endtask

  task automatic t_reload_change();
    do_start(100);
    reload_i = 16'd5;
    clocks(3);
    chk("R9 count unaffected", int'(count_o), 97);
    do_start(5);
    chk("R9 new value on start", int'(count_o), 5);
    do_start(300);
    chk("R2 restart running", int'(count_o), 300);
  endtask

  task automatic t_start_stop();
    reload_i = 16'd40;
    start_i = 1'b1; stop_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; stop_i = 1'b0;
    chk("R10 start wins running", int'(running_o), 1);
    chk("R10 start wins count", int'(count_o), 40);
  endtask

  initial begin
    clocks(3);
    rst_n = 1'b1;
    clocks(1);
    t_reset();
    t_load_and_step();
    t_prescale();
    t_oneshot();
    t_zero_reload();
    t_auto();
    t_stop();
    t_reload_change();
    t_start_stop();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule